// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time as a set of packed BCD fields: seconds, minutes, hours, a day-of-week counter, day of month, month, and a sixteen-bit year that holds the century and the year within the century as two BCD bytes. A clock divider makes a 128 Hz tick from the system clock. A seven-bit sub-second counter counts these ticks, and each time it wraps the seconds advance by one. The carry then moves through the calendar, including the month lengths and the Gregorian leap-year rule.

Software uses a simple synchronous register port. A write strobe, a word index and a 16-bit data word go in, and read data comes back combinationally for the index presented. Every field except the year uses the low byte of the data word. To set the time, software clears the start bit with the prescaler-reset bit set, writes all the fields, and then sets enable and start. A sticky carry flag is set on every second carry and is cleared when software writes 0 to it. Software clears the flag, reads the whole calendar, and checks the flag again: if it is set, the read may be torn and must be retried. A carry interrupt output is driven from the flag and its enable. The register port is plain control access, so it has no back-pressure: every write takes effect at the clock edge where it is strobed.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the fields read: seconds, minutes, hours and weekday 0x00; day 0x01; month 0x01; year 0x2000. Both control words and the sub-second count read 0, and carry_irq is low.
- R2: While start (index 15, bit 0) is 1, the sub-second count at index 0 advances once every CLK_PER_TICK clocks. The seconds field changes exactly 128*CLK_PER_TICK clocks after the edge on which start was written, and not one clock earlier.
- R3: While start is 0, the sub-second count and all time fields hold their values.
- R4: Writing 1 to index 15, bit 1, zeroes the prescaler and the sub-second count on that edge. This bit always reads 0, and so does bit 2. Bit 3 (enable) and bit 0 (start) read back as written.
- R5: Seconds and minutes go from 0x59 to 0x00, and hours go from 0x23 to 0x00, each passing a carry to the next field. Otherwise each field steps by one in BCD.
- R6: When the day of month passes the last day of its month (30 for months 0x04, 0x06, 0x09 and 0x11; 31 for the other non-February months), the day goes back to 0x01 and the month advances. Month 0x12 goes to 0x01 and the year advances. Year low byte 0x99 goes to 0x00 and carries into the century byte, and year 0x9999 goes to 0x0000.
- R7: February has 29 days when the year is divisible by 4, except for century years whose century is not divisible by 4. Otherwise it has 28 days.
- R8: The weekday (index 4) advances together with each day change and goes from 6 back to 0.
- R9: Index 14, bit 7, is set on every second carry. Writing 0 to it clears it and writing 1 leaves it unchanged. If a carry and a clearing write fall on the same edge, the flag ends up set.
- R10: carry_irq is high exactly while the carry flag and its enable (index 14, bit 4) are both 1.
- R11: Fields at indices 1 to 7 read back exactly what was written. The other bits of index 14 read 0. Unmapped indices read 0. Writes to index 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, taken at the rising edge |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 16 | Write data; only the year uses the high byte |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| carry_irq | output | 1 | Carry interrupt, high while flag and enable are both set |

## Verification
The assertions assume that a time field advances only from a legal BCD value, and that software does not write a calendar field on the same edge as a second carry it cares about. Field writes override any carry on that edge, so a property about rollover applies only on edges with no write. The stimulus respects this. Every calendar load is done with start cleared, random dates are drawn only within real month lengths and BCD ranges, and the only write deliberately timed onto a carry edge goes to the control word, where the set-over-clear priority is checked.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam int FIELD_W = 8;
  localparam int NUM_FLD = 7;

  localparam logic [ADDR_W-1:0] IDX_SUBSEC = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IDX_CTRL1  = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] IDX_CTRL2  = ADDR_W'(15);

  typedef struct packed {
    logic [FIELD_W-1:0]   sec;
    logic [FIELD_W-1:0]   min;
    logic [FIELD_W-1:0]   hr;
    logic [FIELD_W-1:0]   wk;
    logic [FIELD_W-1:0]   day;
    logic [FIELD_W-1:0]   mon;
    logic [2*FIELD_W-1:0] yr;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                       wk: 8'h00, day: 8'h01, mon: 8'h01,
                                       yr: 16'h2000};

  function automatic logic [7:0] bcd_inc8(input logic [7:0] b);
    if (b[3:0] == 4'd9) return {b[7:4] + 4'd1, 4'h0};
    return {b[7:4], b[3:0] + 4'd1};
  endfunction

  // two-digit BCD value divisible by four
  function automatic logic bcd_div4(input logic [7:0] b);
    if (!b[4]) return (b[3:0] == 4'd0) || (b[3:0] == 4'd4) || (b[3:0] == 4'd8);
    return (b[3:0] == 4'd2) || (b[3:0] == 4'd6);
  endfunction

  function automatic logic bcd_leap(input logic [15:0] y);
    if (y[7:0] == 8'h00) return bcd_div4(y[15:8]);
    return bcd_div4(y[7:0]);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [15:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CLK_PER_TICK  = 4,
  parameter int TICKS_PER_SEC = 128,
  localparam int SUB_W = $clog2(TICKS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  output logic [SUB_W-1:0] subsec,
  output logic             sec_pulse
);

  localparam int DIV_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_TICK - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick      = run && !clr && (div_q == DIV_LAST);
  assign sec_pulse = tick && (subsec == SUB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      subsec <= '0;
    end else if (clr) begin
      div_q  <= '0;
      subsec <= '0;
    end else if (run) begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
      if (tick) subsec <= sec_pulse ? '0 : subsec + SUB_W'(1);
    end
  end

  a_r2_sub_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> (subsec == '0));

  a_r4_clr_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (subsec == '0) && (div_q == '0));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(subsec));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_bcd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_pulse,
  input  logic [NUM_FLD-1:0]   fld_we,
  input  logic [DATA_W-1:0]    wdata,
  output rtc_time_t            now
);

  logic [7:0] last_day;
  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, y_wrap;
  logic any_we;

  assign last_day = month_last_day(now.mon, now.yr);
  assign s_wrap   = now.sec == 8'h59;
  assign m_wrap   = s_wrap && (now.min == 8'h59);
  assign h_wrap   = m_wrap && (now.hr == 8'h23);
  assign d_wrap   = h_wrap && (now.day == last_day);
  assign mo_wrap  = d_wrap && (now.mon == 8'h12);
  assign y_wrap   = mo_wrap && (now.yr[7:0] == 8'h99);
  assign any_we   = |fld_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= RESET_TIME;
    end else begin
      if (fld_we[0]) now.sec <= wdata[7:0];
      else if (sec_pulse) now.sec <= s_wrap ? 8'h00 : bcd_inc8(now.sec);

      if (fld_we[1]) now.min <= wdata[7:0];
      else if (sec_pulse && s_wrap) now.min <= m_wrap ? 8'h00 : bcd_inc8(now.min);

      if (fld_we[2]) now.hr <= wdata[7:0];
      else if (sec_pulse && m_wrap) now.hr <= h_wrap ? 8'h00 : bcd_inc8(now.hr);

      if (fld_we[3]) now.wk <= wdata[7:0];
      else if (sec_pulse && h_wrap) now.wk <= (now.wk == 8'h06) ? 8'h00 : bcd_inc8(now.wk);

      if (fld_we[4]) now.day <= wdata[7:0];
      else if (sec_pulse && h_wrap) now.day <= d_wrap ? 8'h01 : bcd_inc8(now.day);

      if (fld_we[5]) now.mon <= wdata[7:0];
      else if (sec_pulse && d_wrap) now.mon <= mo_wrap ? 8'h01 : bcd_inc8(now.mon);

      if (fld_we[6]) now.yr <= wdata;
      else if (sec_pulse && mo_wrap) begin
        now.yr[7:0] <= y_wrap ? 8'h00 : bcd_inc8(now.yr[7:0]);
        if (y_wrap)
          now.yr[15:8] <= (now.yr[15:8] == 8'h99) ? 8'h00 : bcd_inc8(now.yr[15:8]);
      end
    end
  end

  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !any_we && now.sec == 8'h59) |=> (now.sec == 8'h00));

  a_r5_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !any_we && now.sec == 8'h59 && now.min == 8'h59 && now.hr == 8'h23)
      |=> (now.hr == 8'h00) && (now.min == 8'h00));

  a_r8_week_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !any_we && now.sec == 8'h59 && now.min == 8'h59 &&
     now.hr == 8'h23 && now.wk == 8'h06) |=> (now.wk == 8'h00));

  a_r6_year_end: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !any_we && now.sec == 8'h59 && now.min == 8'h59 && now.hr == 8'h23 &&
     now.day == 8'h31 && now.mon == 8'h12) |=> (now.mon == 8'h01) && (now.day == 8'h01));

  a_r11_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !any_we) |=> $stable(now));

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic c1_we,
  input  logic c2_we,
  input  logic wr_cf,
  input  logic wr_cie,
  input  logic wr_en,
  input  logic wr_rst,
  input  logic wr_start,
  input  logic sec_pulse,
  output logic cf,
  output logic cie,
  output logic rtc_en,
  output logic run,
  output logic presc_clr,
  output logic carry_irq
);

  assign presc_clr = c2_we && wr_rst;
  assign carry_irq = cf && cie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf     <= 1'b0;
      cie    <= 1'b0;
      rtc_en <= 1'b0;
      run    <= 1'b0;
    end else begin
      if (sec_pulse)             cf <= 1'b1;
      else if (c1_we && !wr_cf)  cf <= 1'b0;
      if (c1_we) cie <= wr_cie;
      if (c2_we) begin
        rtc_en <= wr_en;
        run    <= wr_start;
      end
    end
  end

  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> cf);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cf && !c1_we) |=> cf);

  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && cie && !c1_we) |=> carry_irq);

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_bcd_pkg::*;
#(
  parameter int CLK_PER_TICK  = 4,
  parameter int TICKS_PER_SEC = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              carry_irq
);

  localparam int SUB_W = $clog2(TICKS_PER_SEC);

  logic [SUB_W-1:0]   subsec;
  logic               sec_pulse;
  logic               run, presc_clr, cf, cie, rtc_en;
  logic [NUM_FLD-1:0] fld_we;
  logic               c1_we, c2_we;
  rtc_time_t          now;

  for (genvar gi = 0; gi < NUM_FLD; gi++) begin : g_fld_we
    assign fld_we[gi] = bus_wr && (bus_addr == ADDR_W'(gi + 1));
  end

  assign c1_we = bus_wr && (bus_addr == IDX_CTRL1);
  assign c2_we = bus_wr && (bus_addr == IDX_CTRL2);

  rtc_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .c1_we     (c1_we),
    .c2_we     (c2_we),
    .wr_cf     (bus_wdata[7]),
    .wr_cie    (bus_wdata[4]),
    .wr_en     (bus_wdata[3]),
    .wr_rst    (bus_wdata[1]),
    .wr_start  (bus_wdata[0]),
    .sec_pulse (sec_pulse),
    .cf        (cf),
    .cie       (cie),
    .rtc_en    (rtc_en),
    .run       (run),
    .presc_clr (presc_clr),
    .carry_irq (carry_irq)
  );

  rtc_prescaler #(
    .CLK_PER_TICK  (CLK_PER_TICK),
    .TICKS_PER_SEC (TICKS_PER_SEC)
  ) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clr       (presc_clr),
    .subsec    (subsec),
    .sec_pulse (sec_pulse)
  );

  rtc_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_pulse (sec_pulse),
    .fld_we    (fld_we),
    .wdata     (bus_wdata),
    .now       (now)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_SUBSEC:  bus_rdata = DATA_W'(subsec);
      ADDR_W'(1):  bus_rdata = {8'h00, now.sec};
      ADDR_W'(2):  bus_rdata = {8'h00, now.min};
      ADDR_W'(3):  bus_rdata = {8'h00, now.hr};
      ADDR_W'(4):  bus_rdata = {8'h00, now.wk};
      ADDR_W'(5):  bus_rdata = {8'h00, now.day};
      ADDR_W'(6):  bus_rdata = {8'h00, now.mon};
      ADDR_W'(7):  bus_rdata = now.yr;
      IDX_CTRL1:   bus_rdata = {8'h00, cf, 2'b00, cie, 4'b0000};
      IDX_CTRL2:   bus_rdata = {8'h00, 4'b0000, rtc_en, 2'b00, run};
      default:     bus_rdata = '0;
    endcase
  end

  a_r3_no_carry_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sec_pulse);

endmodule

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;

  localparam int CPT = 4;
  localparam int SEC_CYC = 128 * CPT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        carry_irq;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rtc_bcd_core #(.CLK_PER_TICK(CPT), .TICKS_PER_SEC(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .carry_irq(carry_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    bus_addr = 4'(a); #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] b8(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit is_leap(input int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return is_leap(y) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void step(inout int s, inout int m, inout int h, inout int w,
                               inout int d, inout int mo, inout int y);
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; w = (w == 6) ? 0 : w + 1; d++;
          if (d > dim(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y == 9999) ? 0 : y + 1; end
          end
        end
      end
    end
  endfunction

  task automatic load(input int s, input int m, input int h, input int w,
                      input int d, input int mo, input int y);
    wr(15, 16'h0002);
    wr(1, {8'h00, b8(s)});
    wr(2, {8'h00, b8(m)});
    wr(3, {8'h00, b8(h)});
    wr(4, {8'h00, b8(w)});
    wr(5, {8'h00, b8(d)});
    wr(6, {8'h00, b8(mo)});
    wr(7, {b8(y / 100), b8(y % 100)});
    wr(14, 16'h0000);
  endtask

  task automatic run_case(input string tag, input int s, input int m, input int h,
                          input int w, input int d, input int mo, input int y);
    logic [15:0] v;
    load(s, m, h, w, d, mo, y);
    wr(15, 16'h0009);
    repeat (SEC_CYC) @(posedge clk);
    #2;
    wr(15, 16'h0008);
    step(s, m, h, w, d, mo, y);
    rd(1, v); chk(tag, v, {8'h00, b8(s)});
    rd(2, v); chk(tag, v, {8'h00, b8(m)});
    rd(3, v); chk(tag, v, {8'h00, b8(h)});
    rd(4, v); chk(tag, v, {8'h00, b8(w)});
    rd(5, v); chk(tag, v, {8'h00, b8(d)});
    rd(6, v); chk(tag, v, {8'h00, b8(mo)});
    rd(7, v); chk(tag, v, {b8(y / 100), b8(y % 100)});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v, v2;
    int s, m, h, w, d, mo, y;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;

    // R1 reset values
    rd(0, v);  chk("R1", v, 16'h0000);
    rd(1, v);  chk("R1", v, 16'h0000);
    rd(3, v);  chk("R1", v, 16'h0000);
    rd(5, v);  chk("R1", v, 16'h0001);
    rd(6, v);  chk("R1", v, 16'h0001);
    rd(7, v);  chk("R1", v, 16'h2000);
    rd(14, v); chk("R1", v, 16'h0000);
    rd(15, v); chk("R1", v, 16'h0000);
    chk("R1", 16'(carry_irq), 16'h0000);

    // R11 readback, control bit masking, unmapped and index 0
    wr(2, 16'h0047); rd(2, v); chk("R11", v, 16'h0047);
    wr(7, 16'h1987); rd(7, v); chk("R11", v, 16'h1987);
    wr(14, 16'h006F); rd(14, v); chk("R11", v, 16'h0000);
    wr(14, 16'h00FF); rd(14, v); chk("R11", v, 16'h0010);
    wr(14, 16'h0000);
    rd(9, v); chk("R11", v, 16'h0000);
    wr(0, 16'h0055); rd(0, v); chk("R11", v, 16'h0000);
    // R4 control-2 bit readback
    wr(15, 16'h00FE); rd(15, v); chk("R4", v, 16'h0008);

    // R2 exact second timing; R9 set wins over clear on same edge; R10
    load(30, 10, 5, 2, 15, 6, 2021);
    wr(15, 16'h0009);
    repeat (20) @(posedge clk); #2;
    rd(0, v); chk("R2", v, 16'd5);
    repeat (SEC_CYC - 1 - 20) @(posedge clk); #2;
    rd(1, v); chk("R2", v, 16'h0030);
    wr(14, 16'h0010);
    rd(1, v); chk("R2", v, 16'h0031);
    rd(14, v); chk("R9", v, 16'h0090);
    chk("R10", 16'(carry_irq), 16'h0001);
    wr(14, 16'h0010);
    rd(14, v); chk("R9", v, 16'h0010);
    chk("R10", 16'(carry_irq), 16'h0000);
    wr(14, 16'h0090);
    rd(14, v); chk("R9", v, 16'h0010);

    // R4 prescaler clear while running
    repeat (37) @(posedge clk); #2;
    wr(15, 16'h0003);
    rd(0, v); chk("R4", v, 16'h0000);
    rd(15, v); chk("R4", v, 16'h0001);

    // R3 frozen while stopped
    repeat (50) @(posedge clk); #2;
    wr(15, 16'h0008);
    rd(0, v); rd(1, v2);
    repeat (600) @(posedge clk); #2;
    begin
      logic [15:0] a, b;
      rd(0, a); chk("R3", a, v);
      rd(1, b); chk("R3", b, v2);
    end
    wr(14, 16'h0000);

    // directed calendar corners
    run_case("R5", 59, 59, 23, 1, 10, 3, 2022);
    run_case("R5", 59, 14, 9, 3, 10, 3, 2022);
    run_case("R6", 59, 59, 23, 2, 30, 4, 2023);
    run_case("R6", 59, 59, 23, 5, 31, 12, 1999);
    run_case("R6", 59, 59, 23, 4, 31, 12, 9999);
    run_case("R7", 59, 59, 23, 1, 28, 2, 2000);
    run_case("R7", 59, 59, 23, 1, 28, 2, 1900);
    run_case("R7", 59, 59, 23, 1, 28, 2, 2024);
    run_case("R7", 59, 59, 23, 1, 28, 2, 2023);
    run_case("R7", 59, 59, 23, 1, 29, 2, 2024);
    run_case("R7", 59, 59, 23, 1, 28, 2, 2100);
    run_case("R8", 59, 59, 23, 6, 12, 8, 2015);

    // R10 flag set with enable low keeps irq low
    rd(14, v); chk("R10", v, 16'h0080);
    chk("R10", 16'(carry_irq), 16'h0000);

    // random dates, biased toward rollover points
    for (int i = 0; i < 40; i++) begin
      y  = $urandom_range(9999, 0);
      mo = $urandom_range(12, 1);
      d  = ($urandom_range(1, 0) == 1) ? dim(mo, y) : $urandom_range(dim(mo, y), 1);
      h  = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
      m  = ($urandom_range(3, 0) != 0) ? 59 : $urandom_range(59, 0);
      s  = ($urandom_range(3, 0) != 0) ? 59 : $urandom_range(59, 0);
      w  = $urandom_range(6, 0);
      run_case("R5", s, m, h, w, d, mo, y);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule